// File: doc/BRIEF.md
# Flash Completion Status Poller

This block runs on the host side of a parallel NOR flash. It decides when an embedded program or erase has finished. After the host starts a program or erase, it pulses `start` with an address inside the busy bank. The poller then reads status bytes from that address until it can report the outcome. One pulse on `done` carries the result: `pass` if the operation completed, `fail` if the device reported a timeout or if the poll limit ran out. `poll_count` gives the number of status reads made.

Two completion algorithms are available, and the `mode` input picks one when the poll starts.

- **Data polling** compares bit 7 of each status read against bit 7 of the expected data byte. While the embedded operation runs, the device returns the complement of that bit.
- **Toggle polling** reads in pairs and watches for bit 6 to stop changing between two reads.

Both methods watch bit 5, which the device sets when its internal routine exceeds its time limit. When bit 5 is seen, both methods make a mandatory confirmation read, because completion and timeout can appear together.

Flash read timing is abstracted to a small stream interface.
- A read request is offered on `rd_valid` with `rd_addr`, and is taken when `rd_ready` is high.
- `rd_valid` and `rd_addr` stay unchanged until the request is taken (back-pressure).
- Each accepted request is answered by exactly one cycle of `rsp_valid` carrying `rsp_data`. The poller always accepts a response, so the response path has no ready signal.
- The poller offers the next request only after the response to the previous one.

Top module: `flash_done_poller`

## Requirements
- R1: While reset is low, and after reset is released, `done`, `pass`, `fail`, `busy` and `rd_valid` are 0 and `poll_count` is 0.
- R2: When idle, a `start` pulse latches `mode`, `exp_data` and `poll_addr`, clears `poll_count` and makes the block busy. Every read request of that poll carries the latched address. A `start` while busy has no effect on the result, the count or the addresses.
- R3: A read request stays offered, with its address unchanged, until `rd_ready` is high. No new request is offered until the response to the accepted one has arrived.
- R4: In data mode (`mode`=0), a read whose bit 7 equals bit 7 of `exp_data` ends the poll with pass.
- R5: In data mode, a read with bit 7 unequal and bit 5 = 0 leads to another read.
- R6: In data mode, a read with bit 7 unequal and bit 5 = 1 leads to exactly one more read. That read passes if its bit 7 equals the expected bit, and otherwise ends the poll with fail.
- R7: In toggle mode (`mode`=1), reads are taken in pairs. If bit 6 is equal in both reads of a pair, the poll ends with pass.
- R8: In toggle mode, if bit 6 differs within a pair and bit 5 of the second read is 1, one more pair is read. That pair passes if its bit 6 values are equal, and otherwise ends the poll with fail.
- R9: In toggle mode, if bit 6 differs within a pair and bit 5 of the second read is 0, a new pair is read.
- R10: If polling would continue after a read (R5, R9) and that read brought `poll_count` to `MAX_POLLS`, the poll ends with fail instead.
- R11: `done` is a one-cycle pulse, raised in the cycle after the deciding response, together with exactly one of `pass` or `fail`. At that point `poll_count` equals the number of responses received, and it holds that value until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll (accepted only while idle) |
| mode | input | 1 | 0 = data polling, 1 = toggle polling |
| exp_data | input | DW | Data written by the operation; bit 7 is the expected completion bit |
| poll_addr | input | AW | Address inside the busy bank |
| rd_valid | output | 1 | Read request offered |
| rd_ready | input | 1 | Read request taken |
| rd_addr | output | AW | Read request address |
| rsp_valid | input | 1 | Read response present (one cycle per request) |
| rsp_data | input | DW | Status byte read from the flash |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation completed (with `done`) |
| fail | output | 1 | Timeout or poll limit reached (with `done`) |
| poll_count | output | CW | Number of status reads in the current or last poll |

## Verification
The bench builds the poller with `MAX_POLLS` = 6, `AW` = 20 and `DW` = 8. The small limit makes the poll-limit failure reachable in a handful of reads in both modes: six unanswered data polls, or three toggling pairs. It also keeps each scripted response sequence short. Some runs throttle `rd_ready` every other cycle to exercise the back-pressure rules. Other runs raise `start` mid-poll with a different mode and address, to show that a second start is ignored.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  // Bit positions inside the status byte returned by the flash.
  localparam int unsigned SB_DATA   = 7;  // complement of data while busy
  localparam int unsigned SB_TOGGLE = 6;  // flips on each read while busy
  localparam int unsigned SB_TMO    = 5;  // internal time limit exceeded

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_DATA,       // data polling: ordinary read
    PS_DATA_LAST,  // data polling: confirmation read after timeout bit
    PS_TGL_A,      // toggle polling: first read of a pair
    PS_TGL_B,      // toggle polling: second read of a pair
    PS_TGL_RA,     // toggle confirmation pair, first read
    PS_TGL_RB      // toggle confirmation pair, second read
  } poll_state_e;

endpackage

// File: rtl/fpoll_link.sv
// Request/response handshake toward the flash read engine.
module fpoll_link #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          want,
  input  logic [AW-1:0] addr_in,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  output logic          got
);

  logic waiting;

  assign rd_valid = want & ~waiting;
  assign rd_addr  = addr_in;
  assign got      = waiting & rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting <= 1'b0;
    end else if (rd_valid && rd_ready) begin
      waiting <= 1'b1;
    end else if (got) begin
      waiting <= 1'b0;
    end
  end

endmodule

// File: rtl/fpoll_tally.sv
// Counts completed status reads and flags the read that reaches the limit.
module fpoll_tally #(
  parameter int MAX_POLLS = 1024,
  parameter int CW        = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          bump,
  output logic [CW-1:0] count,
  output logic          at_last
);

  localparam logic [CW-1:0] LAST_AT = CW'(MAX_POLLS - 1);
  localparam logic [CW-1:0] TOP     = '1;

  assign at_last = (count >= LAST_AT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (bump && count != TOP) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/fpoll_judge.sv
// Decision logic: given the current phase and the status byte just read,
// pick the next phase or the final verdict.
module fpoll_judge
  import fpoll_pkg::*;
(
  input  poll_state_e st,
  input  logic        s_data,
  input  logic        s_tgl,
  input  logic        s_tmo,
  input  logic        exp_bit,
  input  logic        prev_tgl,
  input  logic        at_last,
  output poll_state_e nxt,
  output logic        fin,
  output logic        ok
);

  always_comb begin
    nxt = st;
    fin = 1'b0;
    ok  = 1'b0;
    unique case (st)
      PS_DATA: begin
        if (s_data == exp_bit) begin
          fin = 1'b1;
          ok  = 1'b1;
        end else if (s_tmo) begin
          nxt = PS_DATA_LAST;
        end else if (at_last) begin
          fin = 1'b1;
        end else begin
          nxt = PS_DATA;
        end
      end
      PS_DATA_LAST: begin
        fin = 1'b1;
        ok  = (s_data == exp_bit);
      end
      PS_TGL_A:  nxt = PS_TGL_B;
      PS_TGL_B: begin
        if (s_tgl == prev_tgl) begin
          fin = 1'b1;
          ok  = 1'b1;
        end else if (s_tmo) begin
          nxt = PS_TGL_RA;
        end else if (at_last) begin
          fin = 1'b1;
        end else begin
          nxt = PS_TGL_A;
        end
      end
      PS_TGL_RA: nxt = PS_TGL_RB;
      PS_TGL_RB: begin
        fin = 1'b1;
        ok  = (s_tgl == prev_tgl);
      end
      default: nxt = PS_IDLE;
    endcase
  end

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
  import fpoll_pkg::*;
#(
  parameter  int AW        = 20,
  parameter  int DW        = 8,
  parameter  int MAX_POLLS = 1024,
  localparam int CW        = $clog2(MAX_POLLS + 3)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [DW-1:0] exp_data,
  input  logic [AW-1:0] poll_addr,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic [CW-1:0] poll_count
);

  poll_state_e   state, nxt;
  logic [AW-1:0] addr_q;
  logic          exp_q;
  logic          prev_tgl;
  logic          got, fin, ok, at_last, take;
  logic          unused_data;

  assign unused_data = ^{rsp_data, exp_data};
  assign busy        = (state != PS_IDLE);
  assign take        = start & ~busy;

  fpoll_link #(.AW(AW)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .want      (busy),
    .addr_in   (addr_q),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr),
    .rsp_valid (rsp_valid),
    .got       (got)
  );

  fpoll_tally #(.MAX_POLLS(MAX_POLLS), .CW(CW)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (take),
    .bump    (got),
    .count   (poll_count),
    .at_last (at_last)
  );

  fpoll_judge u_judge (
    .st       (state),
    .s_data   (rsp_data[SB_DATA]),
    .s_tgl    (rsp_data[SB_TOGGLE]),
    .s_tmo    (rsp_data[SB_TMO]),
    .exp_bit  (exp_q),
    .prev_tgl (prev_tgl),
    .at_last  (at_last),
    .nxt      (nxt),
    .fin      (fin),
    .ok       (ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= PS_IDLE;
      addr_q   <= '0;
      exp_q    <= 1'b0;
      prev_tgl <= 1'b0;
      done     <= 1'b0;
      pass     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      done <= 1'b0;
      pass <= 1'b0;
      fail <= 1'b0;
      if (take) begin
        addr_q <= poll_addr;
        exp_q  <= exp_data[SB_DATA];
        state  <= mode ? PS_TGL_A : PS_DATA;
      end else if (got) begin
        prev_tgl <= rsp_data[SB_TOGGLE];
        state    <= fin ? PS_IDLE : nxt;
        done     <= fin;
        pass     <= fin & ok;
        fail     <= fin & ~ok;
      end
    end
  end

endmodule

// File: rtl/fpoll_chk.sv
module fpoll_chk #(
  parameter int AW        = 20,
  parameter int MAX_POLLS = 1024,
  parameter int CW        = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          rsp_valid,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic [CW-1:0] poll_count
);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R3
  no_req_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !rd_valid);

  // R11
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail));

  // R11
  verdict_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || fail) |-> done);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !rd_valid));

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_count <= CW'(MAX_POLLS + 2));

  // R11
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$rose(busy)) |=> $stable(poll_count) || busy);

  // R3
  rsp_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !busy) |=> !done);

endmodule

bind flash_done_poller fpoll_chk #(.AW(AW), .MAX_POLLS(MAX_POLLS), .CW(CW)) u_fpoll_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_addr    (rd_addr),
  .rsp_valid  (rsp_valid),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .fail       (fail),
  .poll_count (poll_count)
);

// File: tb/flash_done_poller_bench.sv
module flash_done_poller_bench;

  localparam int AW = 20;
  localparam int DW = 8;
  localparam int MP = 6;
  localparam int CW = $clog2(MP + 3);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mode = 1'b0;
  logic [DW-1:0] exp_data = '0;
  logic [AW-1:0] poll_addr = '0;
  logic          rd_valid;
  logic          rd_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic          rsp_valid = 1'b0;
  logic [DW-1:0] rsp_data = '1;
  logic          busy, done, pass, fail;
  logic [CW-1:0] poll_count;

  always #4 clk = ~clk;

  flash_done_poller #(.AW(AW), .DW(DW), .MAX_POLLS(MP)) u_flash_done_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .exp_data(exp_data),
    .poll_addr(poll_addr), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .poll_count(poll_count)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // {mode, throttle, exp_data, response bytes (byte k at [8k+:8]), pass, count}
  localparam logic [78:0] VT [0:11] = '{
    {1'b0, 1'b0, 8'h80, 64'h80,             1'b1, 4'd1},  // R4 first read matches
    {1'b0, 1'b1, 8'h80, 64'h800000,         1'b1, 4'd3},  // R5 two misses then match
    {1'b0, 1'b0, 8'h80, 64'h8020,           1'b1, 4'd2},  // R6 timeout, confirm pass
    {1'b0, 1'b1, 8'h80, 64'h2020,           1'b0, 4'd2},  // R6 timeout, confirm fail
    {1'b0, 1'b0, 8'h80, 64'h0,              1'b0, 4'd6},  // R10 data limit
    {1'b1, 1'b0, 8'h00, 64'h4040,           1'b1, 4'd2},  // R7 no toggle
    {1'b1, 1'b1, 8'h00, 64'h00000040,       1'b1, 4'd4},  // R9 toggle then settle
    {1'b1, 1'b0, 8'h00, 64'h40406000,       1'b1, 4'd4},  // R8 timeout, confirm pass
    {1'b1, 1'b1, 8'h00, 64'h40006000,       1'b0, 4'd4},  // R8 timeout, confirm fail
    {1'b1, 1'b0, 8'h00, 64'h004000400040,   1'b0, 4'd6},  // R10 toggle limit
    {1'b0, 1'b1, 8'h00, 64'h0080,           1'b1, 4'd2},  // R4 expected bit 0
    {1'b1, 1'b0, 8'h00, 64'h00004020,       1'b1, 4'd4}   // R9 bit5 only in first read
  };

  task automatic run_vec(input int i, input bit poke, input string tag);
    logic [78:0]   v = VT[i];
    logic          m = v[78];
    logic          thr = v[77];
    logic [63:0]   bytes = v[68:5];
    logic [AW-1:0] a = AW'(20'h10000 + i * 20'h111);
    int idx = 0, ndone = 0, got_cnt = 0, addr_bad = 0, tail = -1;
    bit pending = 1'b0, got_pass = 1'b0, got_fail = 1'b0, tail_bad = 1'b0;
    @(negedge clk);
    mode = m; exp_data = v[76:69]; poll_addr = a; start = 1'b1;
    for (int cyc = 0; cyc < 300; cyc++) begin
      @(negedge clk);
      start = 1'b0;
      rsp_valid = 1'b0;
      if (poke && cyc == 2) begin
        start = 1'b1; mode = ~m; poll_addr = ~a; exp_data = ~v[76:69];
      end
      if (tail >= 0) begin
        if (done || rd_valid || busy || int'(poll_count) != got_cnt) tail_bad = 1'b1;
        tail++;
        if (tail == 3) break;
        continue;
      end
      if (done) begin
        ndone++; got_pass = pass; got_fail = fail; got_cnt = int'(poll_count);
        tail = 0;
        continue;
      end
      if (pending) begin
        rsp_valid = 1'b1; rsp_data = bytes[8*idx +: 8]; idx++; pending = 1'b0;
      end
      rd_ready = thr ? cyc[0] : 1'b1;
      if (rd_valid && rd_ready) begin
        pending = 1'b1;
        if (rd_addr != a) addr_bad++;
      end
    end
    start = 1'b0; rd_ready = 1'b0;
    check(ndone == 1, tag, "done pulses (R11)", ndone, 1);
    check(got_pass == v[4] && got_fail == !v[4], tag, "pass flag", got_pass, v[4]);
    check(got_cnt == int'(v[3:0]), tag, "poll count (R11)", got_cnt, int'(v[3:0]));
    check(addr_bad == 0, poke ? "R2" : "R3", "bad request addresses", addr_bad, 0);
    check(!tail_bad, "R11", "outputs quiet and count held after done", tail_bad, 0);
  endtask

  localparam string TAGS [0:11] = '{"R4", "R5", "R6", "R6", "R10", "R7",
                                    "R9", "R8", "R8", "R10", "R4", "R9"};

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!done && !pass && !fail && !busy && !rd_valid, "R1", "outputs in reset",
          {done, pass, fail, busy, rd_valid}, 0);
    check(poll_count == 0, "R1", "count in reset", int'(poll_count), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !rd_valid && !done, "R1", "idle after reset",
          {busy, rd_valid, done}, 0);

    for (int i = 0; i < 12; i++) run_vec(i, 1'b0, TAGS[i]);

    // R2: start while busy is ignored
    run_vec(1, 1'b1, "R2");
    run_vec(7, 1'b1, "R2");
    run_vec(4, 1'b1, "R2");

    // R1: reset in mid-poll clears everything
    @(negedge clk);
    mode = 1'b0; exp_data = 8'h80; poll_addr = 20'h0ABCD; start = 1'b1; rd_ready = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rd_ready = 1'b0;
    @(negedge clk);
    check(!busy && !rd_valid && !done && poll_count == 0, "R1", "state after mid-poll reset",
          {busy, rd_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_vec(0, 1'b0, "R1");

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule